// File: doc/BRIEF.md
# Serial-Peripheral UART Service Sequencer

This block is the host side of a UART that sits behind a 16-bit command-word serial link. It decides which commands go out and in what order. It also works out the parity of outgoing characters, checks the parity of received ones, and tracks the peripheral's clear-to-send line. It holds no shift register of its own. Each command is one 16-bit transfer, made through a request/acknowledge handshake with an external serial engine.

Work happens in service passes. A pass can be started by a falling edge on the peripheral's interrupt line, by a periodic poll tick, or by a local kick.

Each pass runs these steps in this order:
1. A configuration write, if a configuration change is pending.
2. A flow-control-only data write, if the RTS level has changed.
3. A read command.
4. A data write, if the peripheral reports its transmitter empty. A flow-control character goes out ahead of the local byte queue.

Passes run back to back while the peripheral still reports a received character, or while queued bytes wait and transmission is not stopped. Every reply is parsed, whichever command it answers. Each reply can yield a received character and an update to the clear-to-send level.

Top module: `spi_uart_poller`

## Requirements
- R1: After reset no transfer is requested, the queue is not full, and the first pass begins with a configuration write of the default word. The default is 0xC400: command bits 15:14 = 11, payload 0x0400, which unmasks the receive interrupt.
- R2: A pass starts only on a falling edge of `irq_n`, a `poll_tick` pulse or a `kick` pulse. A rising edge of `irq_n` or no trigger at all causes no transfer.
- R3: Within a pass the commands appear in a fixed order:
  - 0xC000 | config, when a configuration is pending;
  - 0x8400 | rts<<9, when an RTS change is pending;
  - the read word 0x0000;
  - the data write, when one is due.
- R4: The data write 0x8000 | rts<<9 | parity<<8 | data is sent only if bit 14 of the reply to the read command is set, and only when there is something to send. A pending `xchar_data` wins over the queue; queued bytes are held while `tx_stop` is high.
- R5: The outgoing parity bit is the XOR of the data bits (7 bits when `seven_bit` is set, otherwise 8), inverted when `par_odd` is set. It is placed in bit 8 only when `par_en` is set. In 7-bit mode data bit 7 is sent as 0.
- R6: Every reply with bit 15 set produces one `rx_valid` pulse.
  - `rx_data` holds the reply's low 8 bits, masked to 7 bits in 7-bit mode.
  - `rx_ferr` is reply bit 10.
  - When bit 10 is clear and `par_en` is set, `rx_perr` flags a mismatch between reply bit 8 and the computed parity. When bit 10 is set, `rx_perr` stays low.
- R7: `cts` follows bit 9 of every reply. `cts_chg` pulses only when that bit differs from the stored level.
- R8: After the read step and the optional write, a new pass starts at once if the latest reply has bit 15 set, or if queued bytes remain and `tx_stop` is low. Otherwise the block goes idle.
- R9: A `shdn_req` pulse makes the block, once idle, send exactly one configuration write, 0xD000, with only the shutdown bit set.
- R10: `spi_req` stays high with `spi_wdata` unchanged until `spi_ack`. No new command is issued before the previous reply has been captured.
- R11: A `cfg_load` or a change of `rts_req` is recorded as a pending commit and applied once, at the start of the next pass. Later passes skip it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Peripheral interrupt line, active low |
| poll_tick | input | 1 | Periodic poll pulse |
| kick | input | 1 | Local service request pulse |
| shdn_req | input | 1 | Request to send the shutdown configuration |
| cfg_load | input | 1 | Latch `cfg_word` and mark it pending |
| cfg_word | input | 14 | Configuration payload |
| rts_req | input | 1 | Desired RTS level |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | Odd parity select |
| seven_bit | input | 1 | 7-bit character mode |
| tx_stop | input | 1 | Hold queued transmit bytes |
| tx_push | input | 1 | Push `tx_byte` into the queue |
| tx_byte | input | 8 | Byte to queue |
| tx_full | output | 1 | Queue full |
| xchar_valid | input | 1 | Flow-control character pending |
| xchar_data | input | 8 | Flow-control character |
| xchar_ack | output | 1 | Flow-control character taken |
| spi_req | output | 1 | Transfer request |
| spi_wdata | output | 16 | Command word |
| spi_ack | input | 1 | Transfer done, reply valid |
| spi_rdata | input | 16 | Reply word |
| rx_valid | output | 1 | Received character strobe |
| rx_data | output | 8 | Received character |
| rx_ferr | output | 1 | Framing error flag |
| rx_perr | output | 1 | Parity error flag |
| cts | output | 1 | Last clear-to-send level |
| cts_chg | output | 1 | Clear-to-send change pulse |
| busy | output | 1 | Pass pending or in progress |

## Verification
The hardest case to reach from the ports is a pass chain in which the read reply first withholds transmitter-empty while a byte waits. The bench has to see the block re-poll, and only later see it send the byte. The bench gets there with a scripted reply list in its serial-engine model: a read reply of 0x0000, then one of 0x4000. This forces a repeat pass that holds the byte back before releasing it.

The parity logic is swept over all 256 byte values in all eight mode combinations. In each sweep the transmit reply carries a received character, so the same pass also checks receive parity, 7-bit masking and the back-to-back pass triggered by reply bit 15.

// File: rtl/spi_uart_poller.sv
module spi_uart_poller #(
  parameter int          QDEPTH      = 4,
  parameter logic [13:0] CFG_DEFAULT = 14'h0400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_n,
  input  logic        poll_tick,
  input  logic        kick,
  input  logic        shdn_req,
  input  logic        cfg_load,
  input  logic [13:0] cfg_word,
  input  logic        rts_req,
  input  logic        par_en,
  input  logic        par_odd,
  input  logic        seven_bit,
  input  logic        tx_stop,
  input  logic        tx_push,
  input  logic [7:0]  tx_byte,
  output logic        tx_full,
  input  logic        xchar_valid,
  input  logic [7:0]  xchar_data,
  output logic        xchar_ack,
  output logic        spi_req,
  output logic [15:0] spi_wdata,
  input  logic        spi_ack,
  input  logic [15:0] spi_rdata,
  output logic        rx_valid,
  output logic [7:0]  rx_data,
  output logic        rx_ferr,
  output logic        rx_perr,
  output logic        cts,
  output logic        cts_chg,
  output logic        busy
);
  localparam int QW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_CFG, S_RTS, S_RD, S_TX, S_CHK, S_SHDN} st_t;

  st_t         state, st_n;
  logic [15:0] word_q, word_n;
  logic [13:0] cfg_q;
  logic        cfg_commit, rts_commit, rts_q;
  logic        start_pend, shdn_pend, irq_q, last_rx;
  logic [7:0]  qmem [QDEPTH];
  logic [QW-1:0] rd_ptr, wr_ptr;
  logic [QW:0]   qcnt;
  logic        pop, take_x, go_first, clr_start, clr_shdn;

  function automatic logic calc_par(input logic [7:0] d, input logic sb, input logic odd);
    return (sb ? ^d[6:0] : ^d) ^ odd;
  endfunction

  function automatic logic [15:0] cmd_word(input st_t s, input logic [13:0] c, input logic r);
    case (s)
      S_CFG:   return {2'b11, c};
      S_RTS:   return {2'b10, 3'b000, 1'b1, r, 9'd0};
      S_SHDN:  return 16'hD000;
      default: return 16'h0000;
    endcase
  endfunction

  wire        trig     = (irq_q & ~irq_n) | poll_tick | kick;
  wire        done     = spi_req & spi_ack;
  wire        q_ready  = (qcnt != '0) & ~tx_stop;
  wire        push_ok  = tx_push & ~tx_full;
  wire [7:0]  tx_sel   = xchar_valid ? xchar_data : qmem[rd_ptr];
  wire [7:0]  tx_d     = seven_bit ? {1'b0, tx_sel[6:0]} : tx_sel;
  wire        tx_p     = par_en & calc_par(tx_d, seven_bit, par_odd);
  wire [7:0]  rd_d     = seven_bit ? {1'b0, spi_rdata[6:0]} : spi_rdata[7:0];
  wire        first_rd = ~cfg_commit & ~rts_commit;

  assign spi_req   = (state == S_CFG) | (state == S_RTS) | (state == S_RD) |
                     (state == S_TX) | (state == S_SHDN);
  assign spi_wdata = word_q;
  assign tx_full   = (qcnt == (QW+1)'(QDEPTH));
  assign busy      = (state != S_IDLE) | start_pend | shdn_pend;

  always_comb begin
    st_n = state; word_n = word_q; pop = 1'b0; take_x = 1'b0;
    go_first = 1'b0; clr_start = 1'b0; clr_shdn = 1'b0;
    case (state)
      S_IDLE: if (shdn_pend) begin st_n = S_SHDN; clr_shdn = 1'b1; end
              else if (start_pend) begin go_first = 1'b1; clr_start = 1'b1; end
      S_CFG:  if (done) st_n = rts_commit ? S_RTS : S_RD;
      S_RTS:  if (done) st_n = S_RD;
      S_RD:   if (done) begin
                if (spi_rdata[14] && (xchar_valid || q_ready)) begin
                  st_n   = S_TX;
                  word_n = {2'b10, 4'd0, rts_q, tx_p, tx_d};
                  take_x = xchar_valid;
                  pop    = ~xchar_valid;
                end else st_n = S_CHK;
              end
      S_TX:   if (done) st_n = S_CHK;
      S_CHK:  if (last_rx || q_ready) go_first = 1'b1; else st_n = S_IDLE;
      S_SHDN: if (done) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
    if (go_first) st_n = cfg_commit ? S_CFG : (rts_commit ? S_RTS : S_RD);
    if (st_n != state && st_n != S_TX) word_n = cmd_word(st_n, cfg_q, rts_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; word_q <= '0; cfg_q <= CFG_DEFAULT;
      cfg_commit <= 1'b1; rts_commit <= 1'b0; rts_q <= 1'b0;
      start_pend <= 1'b0; shdn_pend <= 1'b0; irq_q <= 1'b1; last_rx <= 1'b0;
      rd_ptr <= '0; wr_ptr <= '0; qcnt <= '0; xchar_ack <= 1'b0;
      rx_valid <= 1'b0; rx_data <= '0; rx_ferr <= 1'b0; rx_perr <= 1'b0;
      cts <= 1'b0; cts_chg <= 1'b0;
    end else begin
      state  <= st_n;
      word_q <= word_n;
      irq_q  <= irq_n;
      start_pend <= (start_pend & ~clr_start) | trig;
      shdn_pend  <= (shdn_pend & ~clr_shdn) | shdn_req;
      xchar_ack  <= take_x;

      if (st_n == S_CFG && state != S_CFG) cfg_commit <= 1'b0;
      if (st_n == S_RTS && state != S_RTS) rts_commit <= 1'b0;
      if (cfg_load) begin cfg_q <= cfg_word; cfg_commit <= 1'b1; end
      if (rts_req != rts_q) begin rts_q <= rts_req; rts_commit <= 1'b1; end

      if (push_ok) begin
        qmem[wr_ptr] <= tx_byte;
        wr_ptr <= (wr_ptr == QW'(QDEPTH-1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == QW'(QDEPTH-1)) ? '0 : rd_ptr + 1'b1;
      qcnt <= qcnt + (QW+1)'(push_ok) - (QW+1)'(pop);

      rx_valid <= done & spi_rdata[15];
      rx_ferr  <= done & spi_rdata[15] & spi_rdata[10];
      rx_perr  <= done & spi_rdata[15] & ~spi_rdata[10] & par_en &
                  (spi_rdata[8] != calc_par(rd_d, seven_bit, par_odd));
      cts_chg  <= done & (spi_rdata[9] != cts);
      if (done) begin
        rx_data <= rd_d;
        cts     <= spi_rdata[9];
        last_rx <= spi_rdata[15];
      end
    end
  end

  wire unused_ok = first_rd;
endmodule

// File: rtl/spi_uart_poller_chk.sv
module spi_uart_poller_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_req,
  input logic        spi_ack,
  input logic [15:0] spi_wdata,
  input logic [15:0] spi_rdata,
  input logic        rx_valid,
  input logic        rx_ferr,
  input logic        rx_perr,
  input logic        cts,
  input logic        cts_chg
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req && !spi_ack |=> spi_req && $stable(spi_wdata));

  p_tx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req && spi_ack && spi_wdata == 16'h0000 && !spi_rdata[14] |=> !spi_req);

  p_cts_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cts_chg |-> cts != $past(cts));

  p_ferr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ferr |-> !rx_perr);

  p_rx_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(spi_req && spi_ack && spi_rdata[15]));
endmodule

bind spi_uart_poller spi_uart_poller_chk u_chk (.*);

// File: tb/spi_uart_poller_bench.sv
`timescale 1ns/1ps
module spi_uart_poller_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_n = 1'b1, poll_tick = 1'b0, kick = 1'b0, shdn_req = 1'b0, cfg_load = 1'b0;
  logic [13:0] cfg_word = '0;
  logic rts_req = 1'b0, par_en = 1'b0, par_odd = 1'b0, seven_bit = 1'b0, tx_stop = 1'b0;
  logic tx_push = 1'b0; logic [7:0] tx_byte = '0; logic tx_full;
  logic xchar_valid = 1'b0; logic [7:0] xchar_data = '0; logic xchar_ack;
  logic spi_req, spi_ack = 1'b0; logic [15:0] spi_wdata, spi_rdata = '0;
  logic rx_valid, rx_ferr, rx_perr, cts, cts_chg, busy; logic [7:0] rx_data;

  always #2.5 clk = ~clk;

  spi_uart_poller u_spi_uart_poller (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] rep [8];
  logic [15:0] wlog [16];
  logic [7:0]  rxd [8];
  logic        rxf [8], rxp [8];
  int ri = 0, rn_cnt = 0, wn = 0, rxn = 0, dly = 0, cts_n = 0, xack_n = 0, hs_bad = 0;
  logic [15:0] prev_w = '0;

  always @(negedge clk) begin
    if (spi_ack) begin spi_ack = 1'b0; dly = 0; end
    else if (spi_req) begin
      if (dly != 0 && spi_wdata != prev_w) hs_bad++;
      prev_w = spi_wdata;
      if (dly == 3) begin
        spi_ack = 1'b1;
        spi_rdata = (ri < rn_cnt) ? rep[ri] : 16'h0000;
        ri++;
        if (wn < 16) wlog[wn] = spi_wdata;
        wn++;
      end else dly++;
    end
    if (rx_valid) begin
      if (rxn < 8) begin rxd[rxn] = rx_data; rxf[rxn] = rx_ferr; rxp[rxn] = rx_perr; end
      rxn++;
    end
    if (cts_chg) cts_n++;
    if (xchar_ack) begin xchar_valid = 1'b0; xack_n++; end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual busy expected idle");
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reps(input logic [15:0] a, b, c, d, input int n);
    rep[0] = a; rep[1] = b; rep[2] = c; rep[3] = d;
    rn_cnt = n; ri = 0; wn = 0; rxn = 0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_kick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    wait_idle();
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk) begin tx_push = 1'b1; tx_byte = v; end
    @(negedge clk) tx_push = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 spi_req after reset", spi_req, 0);
    chk("R1 tx_full after reset", tx_full, 0);
    reps(0, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    chk("R2 no trigger no transfer", wn, 0);

    reps(0, 0, 0, 0, 0);
    do_kick();
    chk("R1 count", wn, 2);
    chk("R1 default config word", wlog[0], 16'hC400);
    chk("R3 read follows config", wlog[1], 16'h0000);

    reps(0, 0, 0, 0, 0);
    @(negedge clk) irq_n = 1'b0;
    wait_idle();
    chk("R2 irq falling edge pass", wn, 1);
    wn = 0;
    @(negedge clk) irq_n = 1'b1;
    repeat (15) @(negedge clk);
    chk("R2 irq rising edge ignored", wn, 0);
    reps(0, 0, 0, 0, 0);
    @(negedge clk) poll_tick = 1'b1;
    @(negedge clk) poll_tick = 1'b0;
    wait_idle();
    chk("R2 poll tick pass", wn, 1);

    // R3 R11 ordering with pending config and rts
    @(negedge clk) begin cfg_load = 1'b1; cfg_word = 14'h0123; rts_req = 1'b1; end
    @(negedge clk) cfg_load = 1'b0;
    push(8'h41);
    reps(16'h0000, 16'h0000, 16'h4000, 16'h0000, 4);
    do_kick();
    chk("R3 count", wn, 4);
    chk("R3 config word", wlog[0], 16'hC123);
    chk("R3 rts word", wlog[1], 16'h8600);
    chk("R3 read word", wlog[2], 16'h0000);
    chk("R4 data word", wlog[3], 16'h8241);
    reps(0, 0, 0, 0, 0);
    do_kick();
    chk("R11 commit applied once", wn, 1);

    // R4 stopped queue, then T gating with repeat (R8)
    tx_stop = 1'b1;
    push(8'h33);
    reps(16'h4000, 0, 0, 0, 1);
    do_kick();
    chk("R4 tx_stop holds queue", wn, 1);
    tx_stop = 1'b0;
    reps(16'h0000, 16'h4000, 16'h0000, 0, 3);
    do_kick();
    chk("R8 repeat count", wn, 3);
    chk("R4 no send without T", wlog[1], 16'h0000);
    chk("R4 send after T", wlog[2], 16'h8233);

    // R4 flow-control char first
    push(8'h55);
    @(negedge clk) begin xchar_valid = 1'b1; xchar_data = 8'h13; end
    xack_n = 0;
    reps(16'h4000, 0, 16'h4000, 0, 4);
    do_kick();
    chk("R8 two passes", wn, 4);
    chk("R4 xchar first", wlog[1], 16'h8213);
    chk("R4 queue after xchar", wlog[3], 16'h8255);
    chk("R4 xchar ack once", xack_n, 1);

    // R5 R6 sweep
    for (int m = 0; m < 8; m++) begin
      int bad_tx = 0, bad_rx = 0, bad_n = 0;
      par_en = m[0]; par_odd = m[1]; seven_bit = m[2];
      for (int b = 0; b < 256; b++) begin
        logic [7:0] d; logic p; logic [15:0] ew;
        d = seven_bit ? (8'(b) & 8'h7f) : 8'(b);
        p = ($countones(d) % 2 == 1) ^ par_odd;
        ew = 16'h8200 | (par_en ? {7'd0, p, 8'd0} : 16'd0) | {8'd0, d};
        push(8'(b));
        reps(16'h4000, 16'h8000 | {7'd0, b[0], 8'(b)}, 16'h0000, 0, 3);
        do_kick();
        if (wn != 3 || rxn != 1) bad_n++;
        if (wlog[1] != ew) bad_tx++;
        if (rxd[0] != d || rxf[0] != 1'b0 || rxp[0] != (par_en & (b[0] != p))) bad_rx++;
      end
      chk($sformatf("R8 sweep pass count mode %0d", m), bad_n, 0);
      chk($sformatf("R5 tx parity mode %0d", m), bad_tx, 0);
      chk($sformatf("R6 rx parity mode %0d", m), bad_rx, 0);
    end

    // R6 framing and masking
    par_en = 1'b1; par_odd = 1'b0; seven_bit = 1'b0;
    reps(16'h8541, 0, 0, 0, 1);
    do_kick();
    chk("R6 framing flag", rxf[0], 1);
    chk("R6 no parity on framing", rxp[0], 0);
    par_en = 1'b0; seven_bit = 1'b1;
    reps(16'h80C1, 0, 0, 0, 1);
    do_kick();
    chk("R6 seven bit mask", rxd[0], 8'h41);
    seven_bit = 1'b0;

    // R7
    cts_n = 0;
    reps(16'h0200, 0, 0, 0, 1);
    do_kick();
    chk("R7 cts rise", cts, 1);
    chk("R7 change count", cts_n, 1);
    reps(16'h0200, 0, 0, 0, 1);
    do_kick();
    chk("R7 no change on same level", cts_n, 1);
    reps(0, 0, 0, 0, 0);
    do_kick();
    chk("R7 cts fall", cts, 0);
    chk("R7 fall counted", cts_n, 2);

    // R9
    reps(0, 0, 0, 0, 0);
    @(negedge clk) shdn_req = 1'b1;
    @(negedge clk) shdn_req = 1'b0;
    wait_idle();
    chk("R9 one transfer", wn, 1);
    chk("R9 shutdown word", wlog[0], 16'hD000);

    chk("R10 word stable while waiting", hs_bad, 0);
    summary();
  end
endmodule